// File: doc/BRIEF.md
# Supply Undervoltage Fault Supervisor

This block watches two supply rails of a three-phase gate driver and decides whether the six gate outputs may be switched. The first rail is the regulator rail that feeds the low-side drivers and the bootstrap charge. The second is the logic rail. Each rail arrives as digital comparator flags that are already synchronised. The block turns the flags into two registered fault states with hysteresis. It outputs one global gate-enable and one supply-fault bit.

The regulator rail has a falling-threshold flag and a rising-threshold flag. Between the two thresholds the block holds the state it already had. The logic rail has three flags: an undervoltage flag, a release flag (threshold plus hysteresis) and a deeper gate-drive-disable flag. A variant strap tells the block whether an on-chip LDO regulator is present. On the variant without an LDO, a logic-rail undervoltage only reports a fault. The gates stay enabled unless the deeper disable flag is also asserted. The block powers up with both rails in fault.

Top module: `supply_uv_supervisor`

## Requirements
- R1: While reset is asserted, and after it is released until a rail clears, gate_en is 0 and supply_fault is 1.
- R2: A clock edge that samples vreg_below_fall=1 puts the regulator rail in fault. After that edge gate_en is 0 and supply_fault is 1.
- R3: The regulator-rail fault clears only on an edge that samples vreg_above_rise=1 and vreg_below_fall=0. When both regulator flags are 0 the state is held.
- R4: The logic-rail fault is set on an edge that samples vlog_below_uv=1. It clears only on an edge with vlog_above_rel=1 and vlog_below_uv=0. With neither flag it is held.
- R5: When strap_has_ldo was 1 at reset release, a logic-rail fault forces gate_en to 0.
- R6: When strap_has_ldo was 0 at reset release, a logic-rail fault sets supply_fault. gate_en falls only while the registered vlog_below_gdd is 1.
- R7: supply_fault is 1 exactly when either rail is in fault. gate_en is 1 whenever supply_fault is 0.
- R8: strap_has_ldo is captured on the first clock edge after reset release. Later changes to it have no effect until the next reset.
- R9: If a rail's set flag and clear flag are sampled 1 on the same edge, the fault is set.
- R10: Every output responds one clock edge after the flags are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| strap_has_ldo | input | 1 | Variant strap: 1 = LDO present |
| vreg_above_rise | input | 1 | Regulator rail above its rising threshold |
| vreg_below_fall | input | 1 | Regulator rail below its falling threshold |
| vlog_below_uv | input | 1 | Logic rail below its undervoltage threshold |
| vlog_above_rel | input | 1 | Logic rail above threshold plus hysteresis |
| vlog_below_gdd | input | 1 | Logic rail below the deeper gate-drive-disable threshold |
| gate_en | output | 1 | Global enable for all high-side and low-side gate outputs |
| supply_fault | output | 1 | Supply undervoltage fault indication |

## Verification
Two functions can fall on the same edge: one rail entering fault while the other clears, and the set and clear flags of a single rail arriving together. The vector table provokes both. One row raises the regulator falling flag while the logic rail releases. Another row releases the regulator rail while the logic rail drops. Further rows assert both flags of one rail at once. Each of these rows is judged by whether supply_fault stays 1 and gate_en stays 0 after that edge. A separate run with the no-LDO strap covers the case where the logic-rail fault and the disable flag overlap.

// File: rtl/supply_uv_pkg.sv
package supply_uv_pkg;
  typedef enum logic {
    RAIL_OK    = 1'b0,
    RAIL_FAULT = 1'b1
  } rail_state_e;

  localparam rail_state_e RAIL_POWERUP = RAIL_FAULT;
endpackage

// File: rtl/uv_hyst_latch.sv
module uv_hyst_latch
  import supply_uv_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        set_flag,
  input  logic        clr_flag,
  output rail_state_e state_q
);
  rail_state_e state_d;
  logic        state_en;

  // Set dominates clear; neither flag holds the state.
  always_comb begin
    state_en = set_flag | clr_flag;
    state_d  = set_flag ? RAIL_FAULT : RAIL_OK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= RAIL_POWERUP;
    else if (state_en) state_q <= state_d;
  end
endmodule

// File: rtl/variant_strap_reg.sv
module variant_strap_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_in,
  output logic has_ldo_q,
  output logic armed_q
);
  logic cap_en;

  always_comb cap_en = ~armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      has_ldo_q <= 1'b1;
    end else if (cap_en) begin
      armed_q   <= 1'b1;
      has_ldo_q <= strap_in;
    end
  end
endmodule

// File: rtl/gate_policy.sv
module gate_policy
  import supply_uv_pkg::*;
(
  input  rail_state_e vreg_state,
  input  rail_state_e vlog_state,
  input  logic        has_ldo,
  input  logic        gdd_q,
  output logic        gate_en,
  output logic        supply_fault
);
  logic vlog_blocks;

  always_comb begin
    vlog_blocks  = (vlog_state == RAIL_FAULT) & (has_ldo | gdd_q);
    supply_fault = (vreg_state == RAIL_FAULT) | (vlog_state == RAIL_FAULT);
    gate_en      = (vreg_state == RAIL_OK) & ~vlog_blocks;
  end
endmodule

// File: rtl/supply_uv_supervisor.sv
module supply_uv_supervisor
  import supply_uv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic strap_has_ldo,
  input  logic vreg_above_rise,
  input  logic vreg_below_fall,
  input  logic vlog_below_uv,
  input  logic vlog_above_rel,
  input  logic vlog_below_gdd,
  output logic gate_en,
  output logic supply_fault
);
  rail_state_e vreg_state_q;
  rail_state_e vlog_state_q;
  logic        has_ldo_q;
  logic        armed_q;
  logic        gdd_q;

  uv_hyst_latch u_vreg (
    .clk(clk), .rst_n(rst_n),
    .set_flag(vreg_below_fall), .clr_flag(vreg_above_rise),
    .state_q(vreg_state_q)
  );

  uv_hyst_latch u_vlog (
    .clk(clk), .rst_n(rst_n),
    .set_flag(vlog_below_uv), .clr_flag(vlog_above_rel),
    .state_q(vlog_state_q)
  );

  variant_strap_reg u_strap (
    .clk(clk), .rst_n(rst_n), .strap_in(strap_has_ldo),
    .has_ldo_q(has_ldo_q), .armed_q(armed_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gdd_q <= 1'b1;
    else        gdd_q <= vlog_below_gdd;
  end

  gate_policy u_policy (
    .vreg_state(vreg_state_q), .vlog_state(vlog_state_q),
    .has_ldo(has_ldo_q), .gdd_q(gdd_q),
    .gate_en(gate_en), .supply_fault(supply_fault)
  );
endmodule

// File: rtl/supply_uv_supervisor_chk.sv
module supply_uv_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic vreg_above_rise,
  input logic vreg_below_fall,
  input logic vlog_below_uv,
  input logic vlog_above_rel,
  input logic gate_en,
  input logic supply_fault,
  input logic vreg_fault,
  input logic vlog_fault,
  input logic has_ldo_q,
  input logic armed_q
);
  assert_vreg_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vreg_below_fall |=> (!gate_en && supply_fault));

  assert_vreg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!vreg_above_rise && !vreg_below_fall) |=> $stable(vreg_fault));

  assert_vlog_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vlog_below_uv |=> vlog_fault);

  assert_vlog_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!vlog_below_uv && !vlog_above_rel) |=> $stable(vlog_fault));

  assert_ldo_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && has_ldo_q && vlog_below_uv) |=> !gate_en);

  assert_clean_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_fault |-> gate_en);

  assert_strap_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(armed_q)) |-> $stable(has_ldo_q));

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vreg_below_fall && vreg_above_rise) |=> vreg_fault);
endmodule

bind supply_uv_supervisor supply_uv_supervisor_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .vreg_above_rise(vreg_above_rise), .vreg_below_fall(vreg_below_fall),
  .vlog_below_uv(vlog_below_uv), .vlog_above_rel(vlog_above_rel),
  .gate_en(gate_en), .supply_fault(supply_fault),
  .vreg_fault(vreg_state_q == supply_uv_pkg::RAIL_FAULT),
  .vlog_fault(vlog_state_q == supply_uv_pkg::RAIL_FAULT),
  .has_ldo_q(has_ldo_q), .armed_q(armed_q)
);

// File: tb/supply_uv_supervisor_tb_top.sv
module supply_uv_supervisor_tb_top;
  logic clk, rst_n, strap, rise, fall, uv, rel, gdd;
  logic gate_en, supply_fault;
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 0;

  supply_uv_supervisor dut_i (
    .clk(clk), .rst_n(rst_n), .strap_has_ldo(strap),
    .vreg_above_rise(rise), .vreg_below_fall(fall),
    .vlog_below_uv(uv), .vlog_above_rel(rel), .vlog_below_gdd(gdd),
    .gate_en(gate_en), .supply_fault(supply_fault)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {rise, fall, uv, rel, gdd, exp_gate, exp_fault, req[4:0]}
  localparam int NV = 13;
  localparam logic [11:0] VEC [NV] = '{
    {7'b1001110, 5'd3},   // both rails release
    {7'b0000010, 5'd3},   // hold between thresholds
    {7'b0100001, 5'd2},   // regulator falls
    {7'b0000001, 5'd3},   // hold in fault
    {7'b1000010, 5'd3},   // regulator releases
    {7'b0010001, 5'd5},   // logic rail drops, LDO variant
    {7'b0000001, 5'd4},   // hold logic fault
    {7'b0001010, 5'd4},   // logic rail releases
    {7'b0101001, 5'd7},   // regulator falls while logic releases
    {7'b1010001, 5'd7},   // regulator releases while logic drops
    {7'b1001010, 5'd7},   // both clean
    {7'b1100001, 5'd9},   // regulator set and clear together
    {7'b1011001, 5'd9}    // logic set and clear together
  };

  task automatic check(input logic eg, input logic ef, input int req);
    n_checks++;
    if (gate_en !== eg || supply_fault !== ef) begin
      n_fail++;
      $display("FAIL R%0d: gate_en=%b supply_fault=%b expected gate_en=%b supply_fault=%b",
               req, gate_en, supply_fault, eg, ef);
    end
  endtask

  task automatic step(input logic [4:0] f);
    @(negedge clk);
    {rise, fall, uv, rel, gdd} = f;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    rst_n = 1'b0;
    strap = s;
    {rise, fall, uv, rel, gdd} = 5'b0;
    repeat (2) @(negedge clk);
    check(1'b0, 1'b1, 1);   // R1 during reset
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; strap = 1'b1;
    {rise, fall, uv, rel, gdd} = 5'b0;
    do_reset(1'b1);
    step(5'b0);
    check(1'b0, 1'b1, 1);   // R1 still faulted after release
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][11:7]);
      check(VEC[i][6], VEC[i][5], int'(VEC[i][4:0]));  // R10 one-edge latency
    end

    // No-LDO variant, R6 and R8
    do_reset(1'b0);
    step(5'b10010);
    check(1'b1, 1'b0, 3);
    step(5'b00100);
    check(1'b1, 1'b1, 6);   // R6 fault but gates on
    step(5'b00101);
    check(1'b0, 1'b1, 6);   // R6 deeper threshold disables
    step(5'b00000);
    check(1'b1, 1'b1, 6);   // R6 disable flag gone, fault held
    @(negedge clk); strap = 1'b1;
    step(5'b00000);
    check(1'b1, 1'b1, 8);   // R8 strap change ignored
    step(5'b00100);
    check(1'b1, 1'b1, 8);   // R8 still no-LDO behaviour
    step(5'b00010);
    check(1'b1, 1'b0, 4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL R10: watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule